// File: doc/BRIEF.md
# One-Hot Tag Wakeup Window

This block is the wakeup half of an out-of-order scheduler. Each entry of the window doubles as its own wakeup tag, so there are exactly as many tags as slots. A waiting instruction stores its dependences as a decoded bit vector with one bit per possible producer slot, not as encoded register numbers that must be compared. A table indexed by architectural register records which slot, if any, holds the register's still-pending producer. That table turns source register numbers into slot masks at insertion time.

One instruction can be inserted per cycle. It takes the lowest-numbered free slot. Up to `ISSUE_W` completions can be reported in one cycle, as slot indices. A completion clears the matching bit in every dependence mask, drops stale mapping entries and frees the slot. A slot that is occupied, not yet issued and has an empty dependence mask raises its ready bit. An age-ordered selector grants up to `ISSUE_W` ready slots per cycle, oldest insertion first. A granted slot stays occupied, but never asks again, until its completion arrives.

Top module: `oneHotWakeup`

## Requirements
- R1: An insertion takes the lowest-numbered free slot, and `insSlot` shows that index before the insertion. When all 8 slots are occupied, `insFull` is 1 and an insertion has no effect.
- R2: A source register with no pending producer adds nothing to the dependence mask. The instruction shows ready in the cycle after its insertion edge.
- R3: A source whose producer slot is still occupied keeps the consumer not ready. The consumer turns ready in the cycle after that producer's completion is broadcast.
- R4: If a source's producer completes in the same cycle as the consumer's insertion, the consumer does not record that dependence.
- R5: A completion clears a register's mapping entry only if the entry still names the completing slot. A later writer's mapping survives the completion of an earlier writer.
- R6: Sources are looked up before the same instruction's destination is mapped, so a source equal to the destination depends on the older producer.
- R7: Completions arriving on both broadcast lanes in one cycle each clear their bits and free their slots.
- R8: Each cycle, at most `ISSUE_W` (2) ready slots are granted, chosen by insertion age (oldest first) and not by slot index. A granted slot is no longer ready from the next cycle on.
- R9: A freed slot's bit is removed from every dependence mask before the slot can be reallocated. A consumer is therefore never held back by a newer occupant of its old producer's slot.
- R10: After reset, the window is empty: no ready bits, no grants, `insFull` is 0 and `insSlot` is 0.
- R11: A completion frees its slot, so that slot is available for allocation from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| insValid | input | 1 | Insert an instruction this cycle |
| insSrcA | input | 4 | First source register |
| insSrcB | input | 4 | Second source register |
| insDstVal | input | 1 | The inserted instruction writes a register |
| insDst | input | 4 | Destination register |
| insFull | output | 1 | No free slot |
| insSlot | output | 3 | Slot the next insertion will take |
| cmpValid | input | 2 | Completion lane valid, one bit per lane |
| cmpSlot | input | 6 | Completing slot index per lane; lane 0 in bits 2:0 |
| readyVec | output | 8 | Per-slot ready (occupied, not issued, no open dependence) |
| grantVec | output | 8 | Slots granted issue this cycle |

## Verification
The assertions assume that a completion names only a slot that is occupied and has already been granted. They also assume that the two completion lanes never name the same slot in one cycle. The directed stimulus follows these rules: it sends each completion only after the bench has seen that slot granted, and it never repeats a slot across lanes. Insertions while full and same-cycle insert-plus-complete are driven on purpose, because they are defined behaviour rather than assumptions.

// File: rtl/wakeup_pkg.sv
package wakeup_pkg;
  localparam int WIN_SLOTS = 8;

  // strobes from control to datapath; each vector has one bit per slot
  typedef struct packed {
    logic [WIN_SLOTS-1:0] allocVec;  // one-hot slot written this cycle, or zero
    logic [WIN_SLOTS-1:0] freeVec;   // slots completing this cycle
  } winStrobe_t;
endpackage

// File: rtl/wakeCtrl.sv
module wakeCtrl #(
  parameter int ISSUE_W = 2
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    insValid,
  input  logic [ISSUE_W-1:0]                      cmpValid,
  input  logic [ISSUE_W*$clog2(wakeup_pkg::WIN_SLOTS)-1:0] cmpSlot,
  input  logic [wakeup_pkg::WIN_SLOTS-1:0]        depClear,
  output wakeup_pkg::winStrobe_t                  strb,
  output logic                                    insFull,
  output logic [$clog2(wakeup_pkg::WIN_SLOTS)-1:0] insSlot,
  output logic [wakeup_pkg::WIN_SLOTS-1:0]        readyVec,
  output logic [wakeup_pkg::WIN_SLOTS-1:0]        grantVec
);
  localparam int SLOTS  = wakeup_pkg::WIN_SLOTS;
  localparam int SLOT_W = $clog2(SLOTS);

  logic [SLOTS-1:0] validQ, issuedQ;
  logic [SLOTS-1:0] olderThanQ [SLOTS];  // row i: slots inserted before slot i
  logic [SLOTS-1:0] freeVec, allocVec;
  logic [SLOT_W-1:0] pickIdx;
  logic found;

  always_comb begin
    freeVec = '0;
    for (int w = 0; w < ISSUE_W; w++)
      if (cmpValid[w]) freeVec[cmpSlot[w*SLOT_W +: SLOT_W]] = 1'b1;
  end

  always_comb begin
    pickIdx = '0;
    found   = 1'b0;
    for (int i = 0; i < SLOTS; i++)
      if (!validQ[i] && !found) begin
        pickIdx = SLOT_W'(i);
        found   = 1'b1;
      end
  end

  assign allocVec      = (insValid && found) ? (SLOTS'(1) << pickIdx) : '0;
  assign insFull       = !found;
  assign insSlot       = pickIdx;
  assign strb.allocVec = allocVec;
  assign strb.freeVec  = freeVec;
  assign readyVec      = validQ & ~issuedQ & depClear;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      int olderCnt;
      olderCnt    = $countones(readyVec & olderThanQ[i]);
      grantVec[i] = readyVec[i] && (olderCnt < ISSUE_W);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= '0;
      issuedQ <= '0;
      for (int i = 0; i < SLOTS; i++) olderThanQ[i] <= '0;
    end else begin
      validQ  <= (validQ & ~freeVec) | allocVec;
      issuedQ <= (issuedQ | grantVec) & ~freeVec & ~allocVec;
      for (int i = 0; i < SLOTS; i++) begin
        if (allocVec[i]) olderThanQ[i] <= validQ & ~freeVec;
        else             olderThanQ[i] <= olderThanQ[i] & ~allocVec;
      end
    end
  end
endmodule

// File: rtl/wakeData.sv
module wakeData #(
  parameter int REGS = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  wakeup_pkg::winStrobe_t           strb,
  input  logic [$clog2(REGS)-1:0]          insSrcA,
  input  logic [$clog2(REGS)-1:0]          insSrcB,
  input  logic                             insDstVal,
  input  logic [$clog2(REGS)-1:0]          insDst,
  output logic [wakeup_pkg::WIN_SLOTS-1:0] depClear
);
  localparam int SLOTS = wakeup_pkg::WIN_SLOTS;
  localparam int REG_W = $clog2(REGS);

  logic [SLOTS-1:0] mapQ [REGS];   // one-hot pending producer slot per register
  logic [SLOTS-1:0] depQ [SLOTS];  // one-hot-per-producer dependence mask per slot
  logic [SLOTS-1:0] srcMask;

  // completion bypass: producers finishing now are not recorded
  assign srcMask = (mapQ[insSrcA] | mapQ[insSrcB]) & ~strb.freeVec;

  always_comb begin
    for (int s = 0; s < SLOTS; s++) depClear[s] = (depQ[s] == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < REGS; r++) mapQ[r] <= '0;
      for (int s = 0; s < SLOTS; s++) depQ[s] <= '0;
    end else begin
      for (int r = 0; r < REGS; r++) begin
        if ((strb.allocVec != '0) && insDstVal && (insDst == REG_W'(r)))
          mapQ[r] <= strb.allocVec;
        else
          mapQ[r] <= mapQ[r] & ~strb.freeVec;
      end
      for (int s = 0; s < SLOTS; s++) begin
        if (strb.allocVec[s]) depQ[s] <= srcMask;
        else                  depQ[s] <= depQ[s] & ~strb.freeVec;
      end
    end
  end
endmodule

// File: rtl/oneHotWakeup.sv
module oneHotWakeup #(
  parameter int REGS    = 16,
  parameter int ISSUE_W = 2
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      insValid,
  input  logic [$clog2(REGS)-1:0]                   insSrcA,
  input  logic [$clog2(REGS)-1:0]                   insSrcB,
  input  logic                                      insDstVal,
  input  logic [$clog2(REGS)-1:0]                   insDst,
  output logic                                      insFull,
  output logic [$clog2(wakeup_pkg::WIN_SLOTS)-1:0]  insSlot,
  input  logic [ISSUE_W-1:0]                        cmpValid,
  input  logic [ISSUE_W*$clog2(wakeup_pkg::WIN_SLOTS)-1:0] cmpSlot,
  output logic [wakeup_pkg::WIN_SLOTS-1:0]          readyVec,
  output logic [wakeup_pkg::WIN_SLOTS-1:0]          grantVec
);
  wakeup_pkg::winStrobe_t strb;
  logic [wakeup_pkg::WIN_SLOTS-1:0] depClear;

  wakeCtrl #(.ISSUE_W(ISSUE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .insValid(insValid),
    .cmpValid(cmpValid), .cmpSlot(cmpSlot), .depClear(depClear),
    .strb(strb), .insFull(insFull), .insSlot(insSlot),
    .readyVec(readyVec), .grantVec(grantVec)
  );

  wakeData #(.REGS(REGS)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .insSrcA(insSrcA), .insSrcB(insSrcB),
    .insDstVal(insDstVal), .insDst(insDst), .depClear(depClear)
  );
endmodule

// File: rtl/wakeChk.sv
module wakeChk #(
  parameter int SLOTS   = 8,
  parameter int ISSUE_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               insFull,
  input logic [ISSUE_W-1:0] cmpValid,
  input logic [SLOTS-1:0]   readyVec,
  input logic [SLOTS-1:0]   grantVec
);
  // R8
  grant_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec & ~readyVec) == '0);

  // R8
  grant_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grantVec) <= ISSUE_W);

  // R8
  no_idle_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readyVec != '0) |-> (grantVec != '0));

  // R8
  granted_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec != '0) |=> ((readyVec & $past(grantVec)) == '0));

  // R1
  full_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (insFull && cmpValid == '0) |=> insFull);
endmodule

bind oneHotWakeup wakeChk #(.SLOTS(wakeup_pkg::WIN_SLOTS), .ISSUE_W(ISSUE_W)) uChk (
  .clk(clk), .rstN(rstN), .insFull(insFull), .cmpValid(cmpValid),
  .readyVec(readyVec), .grantVec(grantVec)
);

// File: tb/sim_oneHotWakeup.sv
module sim_oneHotWakeup;
  localparam int RW = 4;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic insValid = 1'b0, insDstVal = 1'b0;
  logic [RW-1:0] insSrcA = '0, insSrcB = '0, insDst = '0;
  logic [1:0] cmpValid = '0;
  logic [2*SW-1:0] cmpSlot = '0;
  logic insFull;
  logic [SW-1:0] insSlot;
  logic [7:0] readyVec, grantVec;
  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  oneHotWakeup u0 (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insSrcA(insSrcA),
    .insSrcB(insSrcB), .insDstVal(insDstVal), .insDst(insDst),
    .insFull(insFull), .insSlot(insSlot), .cmpValid(cmpValid),
    .cmpSlot(cmpSlot), .readyVec(readyVec), .grantVec(grantVec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic iv, input logic [RW-1:0] a, input logic [RW-1:0] b,
                      input logic dv, input logic [RW-1:0] d, input logic [1:0] cv,
                      input logic [SW-1:0] s0, input logic [SW-1:0] s1);
    insValid = iv; insSrcA = a; insSrcB = b; insDstVal = dv; insDst = d;
    cmpValid = cv; cmpSlot = {s1, s0};
    @(negedge clk);
    insValid = 1'b0; insDstVal = 1'b0; cmpValid = '0;
  endtask

  task automatic ins(input logic [RW-1:0] a, input logic [RW-1:0] b,
                     input logic dv, input logic [RW-1:0] d);
    step(1'b1, a, b, dv, d, 2'b00, '0, '0);
  endtask

  task automatic cmp1(input logic [SW-1:0] s);
    step(1'b0, '0, '0, 1'b0, '0, 2'b01, s, '0);
  endtask

  task automatic idle();
    step(1'b0, '0, '0, 1'b0, '0, 2'b00, '0, '0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic tReset();
    doReset();
    chk("R10 ready", 32'(readyVec), 0);
    chk("R10 grant", 32'(grantVec), 0);
    chk("R10 full", 32'(insFull), 0);
    chk("R10 slot", 32'(insSlot), 0);
  endtask

  task automatic tIndep();
    doReset();
    ins(1, 2, 1'b1, 3);
    chk("R2 ready", 32'(readyVec), 32'h01);
    chk("R8 grant", 32'(grantVec), 32'h01);
    chk("R1 next slot", 32'(insSlot), 1);
    idle();
    chk("R8 issued not ready", 32'(readyVec), 0);
    cmp1(0);
    chk("R11 slot freed", 32'(insSlot), 0);
  endtask

  task automatic tDepend();
    doReset();
    ins(1, 2, 1'b1, 3);
    ins(3, 4, 1'b0, 0);
    chk("R3 waiting", 32'(readyVec), 0);
    cmp1(0);
    chk("R3 woken", 32'(readyVec), 32'h02);
    ins(3, 3, 1'b0, 0);
    chk("R5 cleared entry", 32'(readyVec), 32'h01);
  endtask

  task automatic tOverwrite();
    doReset();
    ins(0, 0, 1'b1, 5);
    ins(5, 5, 1'b1, 5);
    chk("R6 src before dst", 32'(readyVec), 0);
    cmp1(0);
    chk("R6 woken by older", 32'(readyVec), 32'h02);
    ins(5, 0, 1'b0, 0);
    chk("R5 later writer kept", 32'(readyVec), 0);
    cmp1(1);
    chk("R5 woken by later writer", 32'(readyVec), 32'h01);
  endtask

  task automatic tBypass();
    doReset();
    ins(0, 0, 1'b1, 6);
    idle();
    step(1'b1, 6, 6, 1'b0, 0, 2'b01, 3'd0, 3'd0);
    chk("R4 bypass ready", 32'(readyVec), 32'h02);
  endtask

  task automatic tMulti();
    doReset();
    ins(0, 0, 1'b1, 1);
    ins(0, 0, 1'b1, 2);
    ins(1, 2, 1'b0, 0);
    chk("R7 before", 32'(readyVec), 0);
    step(1'b0, 0, 0, 1'b0, 0, 2'b11, 3'd0, 3'd1);
    chk("R7 both lanes", 32'(readyVec), 32'h04);
    chk("R7 slot freed", 32'(insSlot), 0);
  endtask

  task automatic tOldest();
    doReset();
    ins(0, 0, 1'b1, 7);
    ins(0, 0, 1'b1, 9);
    ins(7, 7, 1'b0, 0);
    ins(7, 7, 1'b0, 0);
    cmp1(1);
    ins(7, 7, 1'b0, 0);
    chk("R8 waiting", 32'(readyVec), 0);
    chk("R1 next slot", 32'(insSlot), 4);
    cmp1(0);
    chk("R8 three ready", 32'(readyVec), 32'h0E);
    chk("R8 oldest two", 32'(grantVec), 32'h0C);
    idle();
    chk("R8 youngest next", 32'(grantVec), 32'h02);
  endtask

  task automatic tReuse();
    doReset();
    ins(0, 0, 1'b1, 1);
    ins(0, 0, 1'b1, 2);
    ins(1, 2, 1'b0, 0);
    cmp1(0);
    ins(2, 2, 1'b0, 0);
    chk("R9 still waiting", 32'(readyVec), 0);
    cmp1(1);
    chk("R9 reuse no block", 32'(readyVec), 32'h05);
  endtask

  task automatic tFull();
    doReset();
    for (int k = 0; k < 8; k++) ins(0, 0, 1'b0, 0);
    chk("R1 full", 32'(insFull), 1);
    ins(0, 0, 1'b0, 0);
    chk("R1 ignored ready", 32'(readyVec), 0);
    chk("R1 still full", 32'(insFull), 1);
    cmp1(3);
    chk("R11 reopen", 32'(insFull), 0);
    chk("R1 freed slot", 32'(insSlot), 3);
    ins(0, 0, 1'b0, 0);
    chk("R1 refill", 32'(readyVec), 32'h08);
  endtask

  initial begin
    #(200000 * 4);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    @(negedge clk);
    tReset();
    tIndep();
    tDepend();
    tOverwrite();
    tBypass();
    tMulti();
    tOldest();
    tReuse();
    tFull();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule